// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Reads

The block is a 16-bit up-counter that advances from the bus clock through a divider with power-of-two rates. Software controls it over an 8-bit register port. A two-bit select input picks one of three registers. The control register holds a halt bit, a self-clearing clear bit and a 3-bit divide code. The other two registers are read-only and return the upper and lower count bytes.

A 16-bit value cannot be read over an 8-bit bus in one access, and the counter may advance between the two byte reads. To avoid a torn value, reading the upper byte copies the lower byte into a holding buffer. The next lower-byte read returns that copy, so the two bytes come from the same instant.

Register select codes: 0 is control, 1 is the upper count byte, 2 is the lower count byte, and 3 is unused. In the control byte, bits 2:0 are the divide code, bit 5 is halt and bit 7 is clear. A write takes effect at the clock edge that ends the write cycle. Read data is combinational from the select input. The buffer is updated at the edge that ends a read cycle, that is, a cycle with `rd_i` high.

Top module: `ptmr_top`

## Requirements
- R1: After reset, the control register reads 0x00 and the counter starts from 0x0000. With divide code 0 and halt clear, it advances by one on every bus clock edge.
- R2: The 6-bit divide chain is cleared by a clear write and advances on each running edge. For divide code k (0 to 6), the counter advances on the edges where the low k bits of the chain are all 1. After n running edges following a clear, the count is floor(n / 2^k) mod 65536.
- R3: With divide code 7, the counter holds its value.
- R4: Writing control with bit 7 set clears the counter and the divide chain at the same edge, and counting restarts from 0x0000.
- R5: Control bit 7 always reads 0. Bits 7, 6, 4 and 3 read 0. A clear write does not change the holding buffer or its pending state.
- R6: While halt (bit 5) is 1, neither the counter nor the divide chain advances. The write that sets halt still uses the previous halt value, so a tick due at that edge still counts.
- R7: A single control write with both halt and clear set clears the counter, and the counter then stays at 0x0000.
- R8: A read of the upper byte (select 1) returns count bits 15:8 and copies count bits 7:0 into the holding buffer. The next read of the lower byte (select 2) returns the buffered byte and releases the buffer.
- R9: While the buffer is pending, further upper-byte reads leave the buffered byte unchanged.
- R10: A lower-byte read with no pending buffer returns the live count bits 7:0.
- R11: Writes to select 1, 2 and 3 change no state. Select 3 reads 0x00.
- R12: The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Register select (0 control, 1 upper byte, 2 lower byte, 3 unused) |
| wr_i | input | 1 | Write strobe for the selected register |
| rd_i | input | 1 | Read strobe; drives the holding-buffer side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |

## Verification
The assertions check on every cycle that:
- the count either holds or steps by one, including the wrap;
- a clear write zeroes the count, and halt or code 7 freezes it;
- an upper-byte read captures the lower byte, and the buffer stays put while pending;
- the lower-byte read returns the buffer or the live byte, according to the pending state.

Only the bench scenarios can show the exact division rates, including the prescaler phase held across a halt. The same holds for the count reached after a halted interval, the full 65536-step wrap, and coherent values read across a long gap between byte reads.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_CLR_BIT  = 7;
  localparam int CTRL_HALT_BIT = 5;
endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             halt_o,
  output logic [SEL_W-1:0] code_o,
  output logic             clr_o
);
  logic             ctrl_wr;
  logic             halt_q;
  logic [SEL_W-1:0] code_q;
  logic             unused_wdata;

  assign ctrl_wr = wr_i && (sel_i == SEL_CTRL);
  // clear is a pulse, never stored
  assign clr_o   = ctrl_wr && wdata_i[CTRL_CLR_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      code_q <= '0;
    end else if (ctrl_wr) begin
      halt_q <= wdata_i[CTRL_HALT_BIT];
      code_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign halt_o = halt_q;
  assign code_o = code_q;
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             tick_o
);
  localparam int NCODE = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [NCODE-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (run_i) pre_q <= pre_q + 1'b1;
  end

  // tap k fires when the low k chain bits are all ones; codes past PRE_W never fire
  for (genvar k = 0; k < NCODE; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign tap[k] = 1'b1;
    end else if (k <= PRE_W) begin : g_div
      assign tap[k] = &pre_q[k-1:0];
    end else begin : g_off
      assign tap[k] = 1'b0;
    end
  end

  assign tick_o = run_i && tap[code_i];
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptmr_readback.sv
module ptmr_readback
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             halt_i,
  input  logic [SEL_W-1:0] code_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             lat_o,
  output logic [BUS_W-1:0] buf_o
);
  logic [BUS_W-1:0] hi_b, lo_b, ctrl_b;
  logic             lat_q;
  logic [BUS_W-1:0] buf_q;

  assign hi_b = cnt_i[CNT_W-1 -: BUS_W];
  assign lo_b = cnt_i[BUS_W-1:0];

  always_comb begin
    ctrl_b                = '0;
    ctrl_b[SEL_W-1:0]     = code_i;
    ctrl_b[CTRL_HALT_BIT] = halt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
      buf_q <= '0;
    end else if (rd_i && sel_i == SEL_HI && !lat_q) begin
      lat_q <= 1'b1;
      buf_q <= lo_b;
    end else if (rd_i && sel_i == SEL_LO) begin
      lat_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = ctrl_b;
      SEL_HI:   rdata_o = hi_b;
      SEL_LO:   rdata_o = lat_q ? buf_q : lo_b;
      default:  rdata_o = '0;
    endcase
  end

  assign lat_o = lat_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3,
  parameter int PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  logic             halt_q;
  logic [SEL_W-1:0] code_q;
  logic             clr;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             lat_q;
  logic [BUS_W-1:0] lo_buf_q;

  ptmr_ctrl #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .sel_i, .wdata_i,
    .halt_o(halt_q), .code_o(code_q), .clr_o(clr)
  );

  ptmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(clr), .run_i(!halt_q), .code_i(code_q), .tick_o(tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(tick), .cnt_o(cnt_q)
  );

  ptmr_readback #(.CNT_W(CNT_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_rb (
    .clk_i, .rst_ni, .rd_i, .sel_i, .cnt_i(cnt_q), .halt_i(halt_q), .code_i(code_q),
    .rdata_o, .lat_o(lat_q), .buf_o(lo_buf_q)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sel_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [BUS_W-1:0] wdata_i,
  input logic [BUS_W-1:0] rdata_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             halt_q,
  input logic [SEL_W-1:0] code_q,
  input logic             lat_q,
  input logic [BUS_W-1:0] lo_buf_q
);
  logic clr_wr, halt_wr;
  assign clr_wr  = wr_i && sel_i == SEL_CTRL && wdata_i[CTRL_CLR_BIT];
  assign halt_wr = wdata_i[CTRL_HALT_BIT];

  p_step_wrap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> cnt_q == '0);

  p_halt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q && !clr_wr |=> $stable(cnt_q));

  p_park_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && halt_wr |=> ##1 (cnt_q == '0 || !halt_q || $past(clr_wr) || $past(wr_i)));

  p_code7_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q == '1 && !clr_wr |=> $stable(cnt_q));

  p_clr_reads0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_CTRL |-> !rdata_o[CTRL_CLR_BIT]);

  p_clr_keeps_buf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !rd_i |=> $stable(lo_buf_q) && $stable(lat_q));

  p_hi_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && sel_i == SEL_HI && !lat_q |=> lat_q && lo_buf_q == $past(cnt_q[BUS_W-1:0]));

  p_lo_buffered_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q && sel_i == SEL_LO |-> rdata_o == lo_buf_q);

  p_buf_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q && !(rd_i && sel_i == SEL_LO) |=> lat_q && $stable(lo_buf_q));

  p_lo_live_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_q && sel_i == SEL_LO |-> rdata_o == cnt_q[BUS_W-1:0]);

  p_none_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_NONE |-> rdata_o == '0);
endmodule

bind ptmr_top ptmr_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_q(cnt_q), .halt_q(halt_q),
  .code_q(code_q), .lat_q(lat_q), .lo_buf_q(lo_buf_q)
);

// File: tb/ptmr_top_test.sv
`timescale 1ns/1ps
module ptmr_top_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  always #2.5 clk = ~clk;

  ptmr_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  int n_chk = 0, n_fail = 0;

  // reference model built from the requirements
  int m_pre, m_cnt, m_code, m_lat, m_buf, m_stop, m_mask;
  bit m_clr, m_tk;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_code = 0; m_lat = 0; m_buf = 0; m_stop = 0;
    end else begin
      m_clr  = wr && sel == 2'd0 && wdata[7];
      m_mask = (1 << m_code) - 1;
      m_tk   = (m_stop == 0) && m_code < 7 && ((m_pre & m_mask) == m_mask);
      if (rd && sel == 2'd1 && m_lat == 0) begin m_buf = m_cnt & 255; m_lat = 1; end
      else if (rd && sel == 2'd2) m_lat = 0;
      if (m_clr) begin m_cnt = 0; m_pre = 0; end
      else if (m_stop == 0) begin
        m_pre = (m_pre + 1) & 63;
        if (m_tk) m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
      if (wr && sel == 2'd0) begin m_stop = int'(wdata[5]); m_code = int'(wdata[2:0]); end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return {2'b00, m_stop[0], 2'b00, m_code[2:0]};
      2'd1: return 8'(m_cnt >> 8);
      2'd2: return (m_lat != 0) ? 8'(m_buf) : 8'(m_cnt);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // read with a directed expected value; also cross-checked against the model
  task automatic rexp(input string tag, input logic [1:0] s, input logic [7:0] e);
    sel = s; rd = 1'b1;
    #1;
    chk(tag, rdata, e);
    chk({tag, " model"}, rdata, exp_rd(s));
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rmod(input string tag, input logic [1:0] s);
    sel = s; rd = 1'b1;
    #1;
    chk(tag, rdata, exp_rd(s));
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    int v;
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ctrl after reset", rdata, 8'h00);
    #0;
    rexp("R1 ctrl", 2'd0, 8'h00);
    rexp("R1 hi", 2'd1, 8'h00);
    rexp("R1 lo buffered count", 2'd2, 8'h01);

    // R2 R4 every divide rate from a clear
    for (int k = 0; k < 7; k++) begin
      n = int'($urandom_range(1500, 40));
      wreg(2'd0, 8'h80 | 8'(k));
      cyc(n);
      v = n >> k;
      rexp("R2 R4 hi", 2'd1, 8'(v >> 8));
      rexp("R2 R4 lo", 2'd2, 8'(v));
    end

    // R3 code 7 holds
    wreg(2'd0, 8'h80);
    cyc(9);
    wreg(2'd0, 8'h07);
    cyc(40);
    rexp("R3 code7 hold", 2'd2, 8'd10);

    // R6 halt freezes counter and prescaler phase
    wreg(2'd0, 8'h82);
    cyc(13);
    wreg(2'd0, 8'h22);
    cyc(50);
    rexp("R6 halted count", 2'd2, 8'd3);
    wreg(2'd0, 8'h02);
    cyc(21);
    rexp("R6 resumed hi", 2'd1, 8'h00);
    rexp("R6 resumed lo", 2'd2, 8'd8);

    // R7 halt and clear together park at zero
    wreg(2'd0, 8'h80);
    cyc(20);
    wreg(2'd0, 8'hA0);
    cyc(30);
    rexp("R7 parked hi", 2'd1, 8'h00);
    rexp("R7 parked lo", 2'd2, 8'h00);
    rexp("R7 ctrl", 2'd0, 8'h20);

    // R5 clear reads 0, unused bits read 0, clear leaves buffer
    wreg(2'd0, 8'hFD);
    rexp("R5 ctrl readback", 2'd0, 8'h25);
    wreg(2'd0, 8'h80);
    cyc(300);
    rexp("R5 hi before clear", 2'd1, 8'h01);
    wreg(2'd0, 8'h80);
    cyc(5);
    rexp("R5 buffer kept over clear", 2'd2, 8'h2C);

    // R8 R9 coherent read across a gap and repeated hi reads
    wreg(2'd0, 8'h80);
    cyc(700);
    rexp("R8 hi", 2'd1, 8'h02);
    cyc(300);
    rexp("R9 second hi", 2'd1, 8'h03);
    rexp("R9 lo still first capture", 2'd2, 8'hBC);

    // R10 live low byte
    cyc(4);
    rexp("R10 live lo", 2'd2, 8'hEF);
    rexp("R10 live lo again", 2'd2, 8'hF0);

    // R11 writes to count bytes and unused select
    wreg(2'd0, 8'hA0);
    wreg(2'd1, 8'hFF);
    wreg(2'd2, 8'h77);
    wreg(2'd3, 8'h12);
    rexp("R11 hi", 2'd1, 8'h00);
    rexp("R11 lo", 2'd2, 8'h00);
    rexp("R11 ctrl", 2'd0, 8'h20);
    rexp("R11 unused sel", 2'd3, 8'h00);

    // R12 wrap
    wreg(2'd0, 8'h80);
    cyc(65535);
    rexp("R12 lo at max", 2'd2, 8'hFF);
    rexp("R12 hi after wrap", 2'd1, 8'h00);
    rexp("R12 lo after wrap", 2'd2, 8'h00);

    // random mix against the model (R2 R6 R8 R9 R10 R11)
    for (int i = 0; i < 80; i++) begin
      case ($urandom_range(4, 0))
        0: wreg(2'd0, 8'($urandom_range(255, 0)) | 8'h80);
        1: wreg(2'd0, 8'($urandom_range(255, 0)) & 8'h7F);
        2: wreg(2'(  $urandom_range(3, 1)), 8'($urandom_range(255, 0)));
        default: ;
      endcase
      cyc(int'($urandom_range(300, 0)));
      rmod("R8 R9 R10 random read", 2'($urandom_range(3, 0)));
      rmod("R2 R6 random read", 2'($urandom_range(3, 0)));
    end

    summary();
    $finish;
  end
endmodule